// File: doc/BRIEF.md
# NAND Bad Block Marker Checker

This block decides whether a NAND erase block carries a factory bad-block mark. When a check is started, it takes a block number, the number of pages per block and the byte offset of the marker inside the spare area. It then asks a separate page read engine for the spare area of the block's first page. If that marker is clean, it asks for the spare area of the block's last page. The read engine deals with the flash pins. This block only sends page addresses on a valid/ready request channel and takes in the spare bytes on a byte stream whose final beat is tagged.

A marker byte that is not 0xFF marks the block bad. A bad first marker ends the check at once, and the last page is not read. Every byte of each spare stream is taken in, up to and including the tagged final byte, so the engine is always left empty. The result is given as a one-cycle done pulse, with the bad flag valid in that same cycle.

Top module: `nand_bbm_check`

## Requirements
- R1: The first request carries page address block_i * ppb_i, using the values captured when the check started.
- R2: The second request carries page address block_i * ppb_i + ppb_i - 1, which is the last page of the block. With ppb_i = 1 it is the same page as the first request.
- R3: The marker is the spare byte at zero-based position mark_pos_i in the response stream. All other spare bytes have no effect on the result, whatever their values.
- R4: A marker value other than 0xFF, including 0x00, 0xFE and 0x7F, makes the block bad.
- R5: When the first page's marker is bad, done_o is raised with bad_o = 1 and no second request is issued.
- R6: bad_o is 0 at done only when both markers read 0xFF. A bad marker on the last page gives bad_o = 1 after exactly two requests.
- R7: From the accepted request until the beat with rsp_last_i, rsp_ready_o stays high. Every beat is consumed, and bytes after the marker are drained.
- R8: A start_i pulse while a check is in progress is ignored. It causes no extra request, no change of addresses and no extra done pulse.
- R9: done_o is high for exactly one cycle per check. bad_o is low whenever done_o is low.
- R10: Once req_valid_o is raised, it and req_page_o are held unchanged until req_ready_i accepts the request.
- R11: After reset, req_valid_o, rsp_ready_o, done_o and bad_o are all low.
- R12: A spare stream that ends before position mark_pos_i is reached counts as a bad marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a check when the block is idle |
| block_i | input | BLK_W | Block number to check |
| ppb_i | input | PPB_W | Pages per block, at least 1 |
| mark_pos_i | input | POS_W | Marker byte offset inside the spare area |
| req_valid_o | output | 1 | Spare-area read request valid |
| req_ready_i | input | 1 | Read engine accepts the request |
| req_page_o | output | ROW_W | Flat page address of the request |
| rsp_valid_i | input | 1 | Spare byte valid |
| rsp_ready_o | output | 1 | Block takes spare bytes |
| rsp_data_i | input | 8 | Spare byte |
| rsp_last_i | input | 1 | Final byte of the spare stream |
| done_o | output | 1 | One-cycle check-complete pulse |
| bad_o | output | 1 | Block is bad, valid with done_o |

## Verification
The bench fills every spare byte other than the marker with a value that is never 0xFF. A design that samples the wrong offset therefore reports a good block as bad. It puts the marker at the first and at the last byte position, and it also sends a stream that is too short to hold the marker. It logs every request. This catches a design that reads the last page after a bad first marker, one that gets the last-page address wrong (ppb_i = 1, largest block and largest page count), or one that restarts when start_i is pulsed mid-check. The bench also inserts request stalls and gaps in the byte stream, which expose a design that drops a request or miscounts bytes across idle beats.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_FIRST,
    ST_RD_FIRST,
    ST_REQ_LAST,
    ST_RD_LAST,
    ST_FIN
  } bbm_state_e;

  localparam logic [7:0] MARK_CLEAN = 8'hFF;
endpackage

// File: rtl/bbm_addr_gen.sv
module bbm_addr_gen #(
  parameter int BLK_W = 16,
  parameter int PPB_W = 9,
  parameter int ROW_W = BLK_W + PPB_W
) (
  input  logic [BLK_W-1:0] block_i,
  input  logic [PPB_W-1:0] ppb_i,
  input  logic             sel_last_i,
  output logic [ROW_W-1:0] page_o
);
  logic [ROW_W-1:0] base;
  logic [ROW_W-1:0] ofs;

  always_comb begin
    base   = ROW_W'(block_i) * ROW_W'(ppb_i);
    ofs    = sel_last_i ? (ROW_W'(ppb_i) - ROW_W'(1)) : '0;
    page_o = base + ofs;
  end
endmodule

// File: rtl/bbm_spare_scan.sv
module bbm_spare_scan
  import bbm_pkg::*;
#(
  parameter int SPARE_MAX = 64,
  parameter int POS_W     = $clog2(SPARE_MAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic [7:0]       data_i,
  input  logic             last_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             end_o,
  output logic             mark_bad_o
);
  localparam int CNT_W = POS_W + 1;

  logic [CNT_W-1:0] idx_q;
  logic             seen_q, bad_q;
  logic             hit, seen_n, bad_n;

  always_comb begin
    hit        = beat_i && (idx_q == CNT_W'(pos_i));
    seen_n     = seen_q | hit;
    bad_n      = bad_q | (hit && (data_i != MARK_CLEAN));
    // missing marker is treated as bad
    mark_bad_o = bad_n | ~seen_n;
    end_o      = beat_i && last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      seen_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (clear_i || end_o) begin
      idx_q  <= '0;
      seen_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (beat_i) begin
      if (idx_q != {CNT_W{1'b1}}) idx_q <= idx_q + CNT_W'(1);
      seen_q <= seen_n;
      bad_q  <= bad_n;
    end
  end
endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
  import bbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic req_ready_i,
  input  logic scan_end_i,
  input  logic scan_bad_i,
  output logic load_o,
  output logic sel_last_o,
  output logic req_valid_o,
  output logic rsp_ready_o,
  output logic done_o,
  output logic bad_o
);
  bbm_state_e state_q, state_n;
  logic       bad_q, bad_n;

  always_comb begin
    state_n = state_q;
    bad_n   = bad_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) begin state_n = ST_REQ_FIRST; bad_n = 1'b0; end
      ST_REQ_FIRST: if (req_ready_i) state_n = ST_RD_FIRST;
      ST_RD_FIRST:
        if (scan_end_i) begin
          if (scan_bad_i) begin state_n = ST_FIN; bad_n = 1'b1; end
          else            state_n = ST_REQ_LAST;
        end
      ST_REQ_LAST:  if (req_ready_i) state_n = ST_RD_LAST;
      ST_RD_LAST:
        if (scan_end_i) begin state_n = ST_FIN; bad_n = scan_bad_i; end
      ST_FIN:       state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      bad_q   <= bad_n;
    end
  end

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign sel_last_o  = (state_q == ST_REQ_LAST);
  assign req_valid_o = (state_q == ST_REQ_FIRST) || (state_q == ST_REQ_LAST);
  assign rsp_ready_o = (state_q == ST_RD_FIRST) || (state_q == ST_RD_LAST);
  assign done_o      = (state_q == ST_FIN);
  assign bad_o       = done_o && bad_q;
endmodule

// File: rtl/nand_bbm_check.sv
module nand_bbm_check #(
  parameter int BLK_W     = 16,
  parameter int PPB_W     = 9,
  parameter int SPARE_MAX = 64,
  localparam int POS_W    = $clog2(SPARE_MAX),
  localparam int ROW_W    = BLK_W + PPB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic [PPB_W-1:0] ppb_i,
  input  logic [POS_W-1:0] mark_pos_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [ROW_W-1:0] req_page_o,
  input  logic             rsp_valid_i,
  output logic             rsp_ready_o,
  input  logic [7:0]       rsp_data_i,
  input  logic             rsp_last_i,
  output logic             done_o,
  output logic             bad_o
);
  logic [BLK_W-1:0] block_q;
  logic [PPB_W-1:0] ppb_q;
  logic [POS_W-1:0] pos_q;
  logic             load, sel_last, scan_end, scan_bad, beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_q <= '0;
      ppb_q   <= '0;
      pos_q   <= '0;
    end else if (load) begin
      block_q <= block_i;
      ppb_q   <= ppb_i;
      pos_q   <= mark_pos_i;
    end
  end

  assign beat = rsp_valid_i && rsp_ready_o;

  bbm_addr_gen #(.BLK_W(BLK_W), .PPB_W(PPB_W), .ROW_W(ROW_W)) u_addr (
    .block_i    (block_q),
    .ppb_i      (ppb_q),
    .sel_last_i (sel_last),
    .page_o     (req_page_o)
  );

  bbm_spare_scan #(.SPARE_MAX(SPARE_MAX), .POS_W(POS_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (load),
    .beat_i     (beat),
    .data_i     (rsp_data_i),
    .last_i     (rsp_last_i),
    .pos_i      (pos_q),
    .end_o      (scan_end),
    .mark_bad_o (scan_bad)
  );

  bbm_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .req_ready_i (req_ready_i),
    .scan_end_i  (scan_end),
    .scan_bad_i  (scan_bad),
    .load_o      (load),
    .sel_last_o  (sel_last),
    .req_valid_o (req_valid_o),
    .rsp_ready_o (rsp_ready_o),
    .done_o      (done_o),
    .bad_o       (bad_o)
  );
endmodule

// File: rtl/bbm_check_sva.sv
module bbm_check_sva #(
  parameter int ROW_W = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [ROW_W-1:0] req_page_o,
  input logic             rsp_valid_i,
  input logic             rsp_ready_o,
  input logic             rsp_last_i,
  input logic             done_o,
  input logic             bad_o
);
  logic [1:0] req_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         req_cnt <= '0;
    else if (done_o)                     req_cnt <= '0;
    else if (req_valid_o && req_ready_i) req_cnt <= req_cnt + 2'd1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_bad_in_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |-> done_o);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_page_o)));
  assert_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ready_o && !(rsp_valid_i && rsp_last_i)) |=> rsp_ready_o);
  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_o && rsp_ready_o));
  assert_good_two_reads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !bad_o) |-> (req_cnt == 2'd2));
  assert_max_reads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |-> (req_cnt < 2'd2));
  assert_done_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_cnt != 2'd0));
endmodule

bind nand_bbm_check bbm_check_sva #(.ROW_W(ROW_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_page_o  (req_page_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ready_o (rsp_ready_o),
  .rsp_last_i  (rsp_last_i),
  .done_o      (done_o),
  .bad_o       (bad_o)
);

// File: tb/nand_bbm_check_tb_top.sv
`timescale 1ns/1ps
module nand_bbm_check_tb_top;
  localparam int BLK_W = 16, PPB_W = 9, SPARE_MAX = 64;
  localparam int POS_W = $clog2(SPARE_MAX), ROW_W = BLK_W + PPB_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [BLK_W-1:0] block_i = '0;
  logic [PPB_W-1:0] ppb_i = '0;
  logic [POS_W-1:0] mark_pos_i = '0;
  logic req_valid_o, req_ready_i = 1'b0;
  logic [ROW_W-1:0] req_page_o;
  logic rsp_valid_i = 1'b0, rsp_ready_o, rsp_last_i = 1'b0;
  logic [7:0] rsp_data_i = '0;
  logic done_o, bad_o;

  always #2.5 clk_i = ~clk_i;

  nand_bbm_check #(.BLK_W(BLK_W), .PPB_W(PPB_W), .SPARE_MAX(SPARE_MAX)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  // engine model configuration
  int spare_len = 16, req_delay = 0, mpos = 0;
  bit gaps = 0;
  logic [ROW_W-1:0] bad_pg_a = '1, bad_pg_b = '1;
  logic [7:0] bad_val = 8'h00;
  // engine model log
  logic [ROW_W-1:0] req_log [4];
  int req_n = 0, beats = 0, stalls = 0, done_cnt = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] spare_byte(input logic [ROW_W-1:0] pg, input int idx);
    if (idx == mpos) return ((pg == bad_pg_a) || (pg == bad_pg_b)) ? bad_val : 8'hFF;
    return 8'h40 + 8'(idx);   // never 0xFF
  endfunction

  always @(negedge clk_i) if (done_o) done_cnt++;

  // read engine behavioural model
  initial begin
    forever begin
      @(negedge clk_i);
      if (req_valid_o) begin
        repeat (req_delay) @(negedge clk_i);
        if (req_n < 4) req_log[req_n] = req_page_o;
        req_n++;
        req_ready_i = 1'b1;
        @(negedge clk_i);
        req_ready_i = 1'b0;
        for (int i = 0; i < spare_len; i++) begin
          if (gaps && (i % 3 == 1)) begin
            rsp_valid_i = 1'b0;
            @(negedge clk_i);
          end
          rsp_valid_i = 1'b1;
          rsp_data_i  = spare_byte(req_log[(req_n - 1) % 4], i);
          rsp_last_i  = (i == spare_len - 1);
          if (!rsp_ready_o) stalls++;
          beats++;
          @(negedge clk_i);
        end
        rsp_valid_i = 1'b0;
        rsp_last_i  = 1'b0;
      end
    end
  end

  task automatic setup(input int slen, input int pos, input int dly, input bit gp);
    spare_len = slen; mpos = pos; req_delay = dly; gaps = gp;
    bad_pg_a = '1; bad_pg_b = '1; bad_val = 8'h00;
    req_n = 0; beats = 0; stalls = 0; done_cnt = 0;
  endtask

  task automatic run_check(input int blk, input int ppb, input bit exp_bad, input int exp_reqs,
                           input string rq, input bit poke_busy);
    longint first = longint'(blk) * ppb;
    longint last  = first + ppb - 1;
    int waited = 0;
    @(negedge clk_i);
    block_i = BLK_W'(blk); ppb_i = PPB_W'(ppb); mark_pos_i = POS_W'(mpos);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke_busy) begin
      repeat (6) @(negedge clk_i);
      block_i = BLK_W'(blk + 1); ppb_i = PPB_W'(ppb + 1); start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o && waited < 3000) begin @(negedge clk_i); waited++; end
    chk(done_o, {rq, " done seen"}, done_o, 1);
    chk(bad_o == exp_bad, {rq, " bad flag"}, bad_o, exp_bad);
    chk(req_n == exp_reqs, {rq, " request count"}, req_n, exp_reqs);
    chk(req_log[0] == ROW_W'(first), "R1 first page", req_log[0], first);
    if (exp_reqs == 2)
      chk(req_log[1] == ROW_W'(last), "R2 last page", req_log[1], last);
    chk(beats == exp_reqs * spare_len && stalls == 0, "R7 stream drained",
        beats - stalls, exp_reqs * spare_len);
    @(negedge clk_i);
    chk(!done_o && !bad_o, "R9 done one cycle", {done_o, bad_o}, 0);
    repeat (20) @(negedge clk_i);
    chk(done_cnt == 1, {rq, " single done"}, done_cnt, 1);
    chk(req_n == exp_reqs, {rq, " no late request"}, req_n, exp_reqs);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk(!req_valid_o && !rsp_ready_o && !done_o && !bad_o, "R11 reset outputs",
        {req_valid_o, rsp_ready_o, done_o, bad_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!req_valid_o && !done_o, "R11 idle after reset", {req_valid_o, done_o}, 0);
  endtask

  task automatic t_good;       // R1 R2 R6
    setup(16, 5, 0, 0);
    run_check(5, 64, 0, 2, "R6 good block", 0);
  endtask

  task automatic t_first_bad;  // R5 R4 value 0x00
    setup(16, 5, 0, 0);
    bad_pg_a = ROW_W'(3 * 64);
    run_check(3, 64, 1, 1, "R5 first bad", 0);
  endtask

  task automatic t_last_bad;   // R4 R6 value 0xFE
    setup(16, 2, 1, 0);
    bad_pg_b = ROW_W'(10 * 128 - 1); bad_val = 8'hFE;
    run_check(9, 128, 1, 2, "R4 last bad FE", 0);
  endtask

  task automatic t_pos_zero;   // R3 R10 with stalls and gaps
    setup(16, 0, 3, 1);
    run_check(2, 32, 0, 2, "R3 marker pos 0", 0);
  endtask

  task automatic t_pos_end;    // R3 marker at last byte, value 0x7F
    setup(64, 63, 0, 1);
    bad_pg_b = ROW_W'(12 * 16 - 1); bad_val = 8'h7F;
    run_check(11, 16, 1, 2, "R3 marker last byte", 0);
  endtask

  task automatic t_short;      // R12
    setup(8, 10, 0, 0);
    run_check(4, 8, 1, 1, "R12 short stream", 0);
  endtask

  task automatic t_busy;       // R8
    setup(16, 4, 2, 1);
    run_check(6, 20, 0, 2, "R8 start while busy", 1);
  endtask

  task automatic t_ppb_one;    // R2 same page twice
    setup(16, 1, 0, 0);
    run_check(7, 1, 0, 2, "R2 one page per block", 0);
  endtask

  task automatic t_big;        // R1 R2 widest addresses
    setup(16, 9, 0, 0);
    run_check(65535, 511, 0, 2, "R1 largest address", 0);
  endtask

  initial begin
    t_reset();
    t_good();
    t_first_bad();
    t_last_bad();
    t_pos_zero();
    t_pos_end();
    t_short();
    t_busy();
    t_ppb_one();
    t_big();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule